// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that fetches, decodes and retires one instruction on every clock edge. It executes a fixed nine-instruction subset of a classic three-format load/store instruction set. The subset covers word load and word store, five register-to-register operations (add, subtract, AND, OR, signed set-less-than), branch-if-equal and an absolute jump. The core holds its own instruction memory and its own data memory. It also contains a 32-entry register file, a main decoder, an ALU-function decoder, a sign extender and the logic that forms the branch and jump targets.

Both memories are filled through a simple load port while the core is held in reset. After reset is released, the core runs the program from address zero. Each retired instruction shows its effect at the ports:

- the current fetch address;
- a register write-back strobe with its destination and value;
- a data-store strobe with its byte address and value.

An integrating block or a bench can follow execution from these ports, one instruction per cycle.

Top module: `sc_core`

## Requirements
- R1: While reset is asserted, and until the internally synchronised release has passed two clock edges, the PC reads 0 and neither `wb_en` nor `st_en` is high. The first instruction executed is the one at address 0.
- R2: An instruction that is neither a taken branch nor a jump sets the next PC to PC+4. The memories are word-indexed by address bits [log2(MEM_WORDS)+1:2].
- R3: Opcode 0x00 (bits [31:26]) selects a register operation on rs [25:21] and rt [20:16], and writes the result to rd [15:11]. The funct field [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and 0x2A signed set-less-than, which gives 1 or 0.
- R4: Opcode 0x23 loads the data word at address rs + sign-extended [15:0] into register rt.
- R5: Opcode 0x2B stores register rt to the data word at address rs + sign-extended [15:0], with no register write. A later load from the same address returns the stored value.
- R6: Opcode 0x04 writes nothing. When rs equals rt, the next PC is PC+4 + (sign-extended [15:0] << 2); otherwise it is PC+4. Negative offsets branch backwards.
- R7: Opcode 0x02 writes nothing and sets the next PC to {PC+4 [31:28], instr [25:0], 2'b00}.
- R8: Register 0 always reads as zero. A write whose destination is register 0 is dropped and does not raise `wb_en`.
- R9: An opcode outside the five listed, or a funct code outside the five listed under opcode 0x00, writes neither the register file nor data memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| ld_imem_we | input | 1 | Writes `ld_data` to instruction word `ld_addr` |
| ld_dmem_we | input | 1 | Writes `ld_data` to data word `ld_addr`; has priority over core stores |
| ld_addr | input | log2(MEM_WORDS) | Word index for the load port |
| ld_data | input | 32 | Word to preload |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| wb_en | output | 1 | Register file is written at the next rising edge |
| wb_addr | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value of that write |
| st_en | output | 1 | Data memory is written at the next rising edge |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Value stored |

## Verification
The assertions assume that every reachable PC fetches a defined word. They also assume that the load port stays idle once the core runs, since a preload write would otherwise hide a store. The stimulus meets both conditions. It fills every word of both memories before releasing reset, and the program it runs ends in a branch onto itself. It does not touch the load port again afterwards. A nested loop in that program sweeps every ordered pair from a set of six operands, including the signed extremes and equal values. In this way each register operation, a store and reload at a negative offset, and both branch outcomes are exercised on all 36 pairs.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluop_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic   dst_is_rd;
    logic   b_is_imm;
    logic   wb_from_mem;
    logic   reg_write;
    logic   mem_read;
    logic   mem_write;
    logic   branch;
    logic   jump;
    aluop_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctl,
  output alu_fn_e    fn,
  output logic       fn_ok
);
  // main decoder
  always_comb begin
    ctl = '0;
    case (op)
      OP_RTYPE: begin
        ctl.dst_is_rd = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.alu_op    = AOP_FUNCT;
      end
      OP_LW: begin
        ctl.b_is_imm    = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.reg_write   = 1'b1;
        ctl.mem_read    = 1'b1;
        ctl.alu_op      = AOP_ADD;
      end
      OP_SW: begin
        ctl.b_is_imm  = 1'b1;
        ctl.mem_write = 1'b1;
        ctl.alu_op    = AOP_ADD;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = AOP_SUB;
      end
      OP_J: ctl.jump = 1'b1;
      default: ctl = '0;  // R9: unknown opcode is a no-op
    endcase
  end

  // ALU function decoder
  always_comb begin
    fn    = ALU_ADD;
    fn_ok = 1'b1;
    case (ctl.alu_op)
      AOP_ADD: fn = ALU_ADD;
      AOP_SUB: fn = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD:  fn = ALU_ADD;
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          default: fn_ok = 1'b0;  // R9: unknown funct blocks the write
        endcase
      end
      default: fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  output logic [W-1:0]   rd1,
  output logic [W-1:0]   rd2,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [W-1:0]   wd
);
  logic [W-1:0] regs [NREGS];

  // R8: entry 0 is never read from storage
  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_imem_we,
  input  logic            ld_dmem_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] pc_o,
  output logic            wb_en,
  output logic [4:0]      wb_addr,
  output logic [XLEN-1:0] wb_data,
  output logic            st_en,
  output logic [XLEN-1:0] st_addr,
  output logic [XLEN-1:0] st_data
);
  // reset: asynchronous assert, synchronised release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, instr, imm_ext, br_tgt, j_tgt;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, mem_rd, wb_val;
  logic [4:0]      dst;
  logic            alu_zero, fn_ok, rf_we;
  logic [AW-1:0]   dm_idx;
  ctrl_t           ctl;
  alu_fn_e         fn;

  assign instr    = imem[pc_q[AW+1:2]];
  assign pc_plus4 = pc_q + 32'd4;
  assign imm_ext  = {{16{instr[15]}}, instr[15:0]};
  assign br_tgt   = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};

  sc_ctrl u_ctrl (
    .op    (instr[31:26]),
    .funct (instr[5:0]),
    .ctl   (ctl),
    .fn    (fn),
    .fn_ok (fn_ok)
  );

  assign dst   = ctl.dst_is_rd ? instr[15:11] : instr[20:16];
  assign rf_we = rst_sync_n & ctl.reg_write & fn_ok & (dst != 5'd0);

  sc_regfile #(.NREGS(32), .W(XLEN)) u_rf (
    .clk (clk),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .we  (rf_we),
    .wa  (dst),
    .wd  (wb_val)
  );

  assign alu_b = ctl.b_is_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign dm_idx = alu_y[AW+1:2];
  assign mem_rd = ctl.mem_read ? dmem[dm_idx] : '0;
  assign wb_val = ctl.wb_from_mem ? mem_rd : alu_y;
  assign st_en  = rst_sync_n & ctl.mem_write;

  // next-PC selection: sequential, then branch, then jump
  always_comb begin
    pc_d = pc_plus4;
    if (ctl.branch && alu_zero) pc_d = br_tgt;
    if (ctl.jump)               pc_d = j_tgt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  always_ff @(posedge clk) begin
    if (ld_imem_we) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_dmem_we) dmem[ld_addr] <= ld_data;
    else if (st_en) dmem[dm_idx]  <= rt_val;
  end

  assign pc_o    = pc_q;
  assign wb_en   = rf_we;
  assign wb_addr = dst;
  assign wb_data = wb_val;
  assign st_addr = alu_y;
  assign st_data = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic            wb_en,
  input logic [4:0]      wb_addr,
  input logic            st_en
);
  logic [5:0]      op;
  logic [XLEN-1:0] seq, br, jt;
  logic            known;

  assign op    = instr[31:26];
  assign seq   = pc + 32'd4;
  assign br    = seq + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jt    = {seq[31:28], instr[25:0], 2'b00};
  assign known = (op == OP_RTYPE) || (op == OP_LW) || (op == OP_SW) ||
                 (op == OP_BEQ) || (op == OP_J);

  a_r1_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_BEQ && op != OP_J) |=> pc == $past(seq));

  a_r5_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !wb_en);

  a_r6_beq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BEQ) |-> (!wb_en && !st_en));

  a_r6_beq_target: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BEQ) |=> (pc == $past(seq) || pc == $past(br)));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_J) |=> pc == $past(jt));

  a_r8_no_r0_write: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_addr != 5'd0);

  a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> (!wb_en && !st_en));
endmodule

bind sc_core sc_core_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .pc      (pc_o),
  .instr   (instr),
  .wb_en   (wb_en),
  .wb_addr (wb_addr),
  .st_en   (st_en)
);

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int MW   = 64;
  localparam int AW   = $clog2(MW);
  localparam int HALT = 27 * 4;

  logic          clk, rst_n, ld_imem_we, ld_dmem_we;
  logic [AW-1:0] ld_addr;
  logic [31:0]   ld_data, pc_o, wb_data, st_addr, st_data;
  logic          wb_en, st_en;
  logic [4:0]    wb_addr;

  sc_core #(.MEM_WORDS(MW)) i_sc_core (
    .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .wb_en(wb_en),
    .wb_addr(wb_addr), .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr),
    .st_data(st_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rt_(input int rs, input int rt, input int rd,
                                      input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_(input logic [5:0] op, input int rs,
                                      input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] jt_(input int tgt);
    return {6'h02, tgt[25:0]};
  endfunction

  logic [31:0] prog [MW];
  logic [31:0] m_d  [MW];
  logic [31:0] m_r  [32];
  logic [31:0] m_pc;

  initial begin
    for (int k = 0; k < MW; k++) begin prog[k] = 32'h0; m_d[k] = 32'h0; end
    for (int k = 0; k < 32; k++) m_r[k] = 32'h0;
    m_d[0] = 32'd5;         m_d[1] = 32'd3;         m_d[2] = 32'hFFFF_FFF9;
    m_d[3] = 32'h7FFF_FFFF; m_d[4] = 32'h8000_0000; m_d[5] = 32'h0F0F_00FF;
    m_d[8] = 32'd4; m_d[9] = 32'd24; m_d[10] = 32'd100;
    prog[0]  = it_(6'h23, 0, 12, 32);
    prog[1]  = it_(6'h23, 0, 13, 36);
    prog[2]  = it_(6'h23, 0, 14, 40);
    prog[3]  = rt_(0, 0, 10, 6'h20);
    prog[4]  = rt_(0, 0, 11, 6'h20);
    prog[5]  = it_(6'h23, 10, 1, 0);
    prog[6]  = it_(6'h23, 11, 2, 0);
    prog[7]  = rt_(1, 2, 3, 6'h20);
    prog[8]  = rt_(1, 2, 4, 6'h22);
    prog[9]  = rt_(1, 2, 5, 6'h24);
    prog[10] = rt_(1, 2, 6, 6'h25);
    prog[11] = rt_(1, 2, 7, 6'h2A);
    prog[12] = it_(6'h2B, 14, 4, -8);
    prog[13] = it_(6'h2B, 14, 7, 0);
    prog[14] = it_(6'h23, 14, 9, -8);
    prog[15] = it_(6'h04, 1, 2, 1);
    prog[16] = rt_(1, 0, 8, 6'h20);
    prog[17] = rt_(11, 12, 11, 6'h20);
    prog[18] = it_(6'h04, 11, 13, 1);
    prog[19] = jt_(5);
    prog[20] = rt_(10, 12, 10, 6'h20);
    prog[21] = it_(6'h04, 10, 13, 1);
    prog[22] = jt_(4);
    prog[23] = rt_(1, 2, 0, 6'h20);
    prog[24] = rt_(0, 0, 15, 6'h25);
    prog[25] = 32'hFFFF_FFFF;
    prog[26] = rt_(1, 2, 16, 6'h3F);
    prog[27] = it_(6'h04, 0, 0, -1);
  end

  string pc_tag = "R1";
  bit    done   = 1'b0;

  task automatic step_and_check();
    logic [31:0] ins, a, b, imm, val, addr, npc;
    logic [5:0]  op;
    logic [4:0]  rs, rt, rd, wa;
    logic        e_wb, e_st;
    string       tag;
    ins = prog[m_pc[AW+1:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a = m_r[rs]; b = m_r[rt]; imm = {{16{ins[15]}}, ins[15:0]};
    e_wb = 1'b0; e_st = 1'b0; val = 32'h0; addr = 32'h0; wa = rt;
    npc = m_pc + 32'd4; tag = "R9";
    chk(pc_tag, "pc", pc_o, m_pc);
    case (op)
      6'h00: begin
        wa = rd; tag = (rd == 5'd0) ? "R8" : "R3";
        e_wb = 1'b1;
        case (ins[5:0])
          6'h20: val = a + b;
          6'h22: val = a - b;
          6'h24: val = a & b;
          6'h25: val = a | b;
          6'h2A: val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin e_wb = 1'b0; tag = "R9"; end
        endcase
        if (rd == 5'd0) e_wb = 1'b0;
      end
      6'h23: begin
        tag = "R4"; addr = a + imm; val = m_d[addr[AW+1:2]]; e_wb = (rt != 5'd0);
      end
      6'h2B: begin tag = "R5"; e_st = 1'b1; addr = a + imm; end
      6'h04: begin
        tag = "R6";
        if (a == b) npc = m_pc + 32'd4 + {imm[29:0], 2'b00};
      end
      6'h02: begin
        tag = "R7"; npc = {npc[31:28], ins[25:0], 2'b00};
      end
      default: tag = "R9";
    endcase
    chk(tag, "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
    if (e_wb) begin
      chk(tag, "wb_addr", {27'd0, wb_addr}, {27'd0, wa});
      chk(tag, "wb_data", wb_data, val);
    end
    chk(tag, "st_en", {31'd0, st_en}, {31'd0, e_st});
    if (e_st) begin
      chk(tag, "st_addr", st_addr, addr);
      chk(tag, "st_data", st_data, b);
    end
    if (e_wb) m_r[wa] = val;
    if (e_st) m_d[addr[AW+1:2]] = b;
    pc_tag = (op == 6'h04) ? "R6" : (op == 6'h02) ? "R7" : "R2";
    if (npc == m_pc && m_pc == HALT) done = 1'b1;
    m_pc = npc;
  endtask

  initial begin
    logic [31:0] dcopy [MW];
    rst_n = 1'b1; ld_imem_we = 1'b0; ld_dmem_we = 1'b0;
    ld_addr = '0; ld_data = '0;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", pc_o, 32'h0);
    chk("R1", "wb_en in reset", {31'd0, wb_en}, 32'h0);
    chk("R1", "st_en in reset", {31'd0, st_en}, 32'h0);
    for (int k = 0; k < MW; k++) dcopy[k] = m_d[k];
    for (int k = 0; k < MW; k++) begin
      ld_imem_we = 1'b1; ld_dmem_we = 1'b1;
      ld_addr = k[AW-1:0]; ld_data = prog[k];
      @(negedge clk);
      ld_imem_we = 1'b0; ld_data = dcopy[k];
      @(negedge clk);
    end
    ld_imem_we = 1'b0; ld_dmem_we = 1'b0;
    chk("R1", "pc after preload", pc_o, 32'h0);
    rst_n = 1'b1;
    @(posedge clk);
    #1 chk("R1", "pc during release", pc_o, 32'h0);
    @(posedge clk);
    @(negedge clk);
    m_pc = 32'h0;
    for (int cyc = 0; cyc < 5000 && !done; cyc++) begin
      step_and_check();
      @(negedge clk);
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: program never reached halt act=%h exp=%h", pc_o, HALT);
    end
    chk("R8", "r15 reads zero from r0", m_r[15], 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule